// File: doc/BRIEF.md
# Link Reset and Clock-Mode Controller

This block decides how the serial audio link of a codec comes out of reset and which clock feeds it. It watches an active-low link reset pin, the SYNC line and the incoming bit clock. All of these are sampled in a free-running reference clock domain. From what it sees, it produces three things. It drives a full hardware reset for a cold reset. It drives a register-only reset for a write to register index zero. It drops the link-active flag for the duration of a warm reset.

The block also chooses the clock mode. While the reset pin is held, it counts rising edges of the bit clock. If enough edges arrive before release, the codec becomes a consumer of the external bit clock. Otherwise it produces the bit clock from a crystal. A strap pin, latched once after power-on, selects which crystal frequency is used. Clock sources themselves are outside the block. It reports them only through a select code.

Top module: `link_reset_ctrl`

## Requirements
- R1: While `por_n` is low, `hw_rst_o` and `reg_rst_o` are 1, `link_active_o` and `bclk_consumer_o` are 0, and `clk_src_o` is 2'b01 (the pull-up default of the strap).
- R2: A cold reset starts when `link_rst_n` is sampled low on COLD_MIN consecutive clock edges. From the following cycle, `hw_rst_o` and `reg_rst_o` are 1 and `link_active_o` is 0. A low pulse of COLD_MIN-1 edges has no effect.
- R3: From a cold reset, the first clock edge that samples `link_rst_n` high makes `hw_rst_o` and `reg_rst_o` 0 and `link_active_o` 1.
- R4: Rising edges of `bclk_in` sampled while `link_rst_n` is low are counted. At release, a count of at least CONSUMER_EDGES sets `bclk_consumer_o` to 1 and `clk_src_o` to 2'b10. A lower count sets `bclk_consumer_o` to 0. The decision is made again at every cold reset.
- R5: `xtal_sel` is latched on the first clock edge after `por_n` rises. A latched 0 gives `clk_src_o` 2'b00 and a latched 1 gives 2'b01 whenever the block is not a consumer. Later changes of `xtal_sel`, including changes across cold resets, are ignored.
- R6: With the link active, `wr_stb` high and `wr_addr` zero make `reg_rst_o` 1 for the next cycle only, and leave `hw_rst_o` at 0 and `link_active_o` at 1. A write to any other address leaves `reg_rst_o` at 0.
- R7: A warm reset starts when `sync_in` is high on WARM_MIN consecutive edges with the link active, `link_rst_n` high and no `bclk_in` rising edge. `link_active_o` then falls, while `reg_rst_o`, `bclk_consumer_o` and `clk_src_o` stay unchanged. `link_active_o` returns to 1 one cycle after `sync_in` is sampled low.
- R8: A rising edge of `bclk_in` restarts the warm-reset count, so SYNC held high on a toggling bit clock never starts a warm reset.
- R9: SYNC high during a cold reset is not counted toward a warm reset. The count starts at zero on release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running reference clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous |
| link_rst_n | input | 1 | Link reset pin, active low |
| sync_in | input | 1 | SYNC line of the link |
| bclk_in | input | 1 | Bit clock as seen at the pin |
| xtal_sel | input | 1 | Crystal-select strap |
| wr_stb | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Register index of the write |
| hw_rst_o | output | 1 | Full hardware reset |
| reg_rst_o | output | 1 | Register-file reset |
| link_active_o | output | 1 | Link is running |
| bclk_consumer_o | output | 1 | Bit clock is taken from outside |
| clk_src_o | output | 2 | 00 crystal 24.576 MHz, 01 crystal 14.318 MHz, 10 external 12.288 MHz bit clock |

## Verification
A wrong state register shows at the ports at once, because the three reset outputs and the link flag are decoded straight from it. A stuck or early transition appears within the cycle counts fixed by COLD_MIN and WARM_MIN, so the bench samples at exactly those cycles and one cycle before them. An edge counter that is wrong, or that is not cleared, shows only when the pin is released. It appears there as a wrong consumer flag and source code, which is why the 4-edge and 5-edge cases sit next to each other. A strap that is latched again, or a warm count that runs on during a cold reset, shows only after a later reset. The bench therefore repeats resets after changing these inputs.

// File: rtl/lrc_pkg.sv
package lrc_pkg;

    typedef enum logic [1:0] {
        ST_COLD   = 2'd0,
        ST_ACTIVE = 2'd1,
        ST_WARM   = 2'd2
    } lrc_state_e;

    typedef enum logic [1:0] {
        SRC_XTAL_24M = 2'b00,
        SRC_XTAL_14M = 2'b01,
        SRC_EXT_BCLK = 2'b10
    } lrc_src_e;

    typedef struct packed {
        lrc_state_e state;
        logic       consumer;
        logic       strap;
        logic       strap_done;
        logic       reg_pulse;
        logic       bclk_prev;
    } lrc_regs_t;

endpackage

// File: rtl/lrc_sat_counter.sv
module lrc_sat_counter #(
    parameter int WIDTH = 3,
    parameter int LIMIT = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             inc,
    output logic [WIDTH-1:0] cnt
);
    localparam logic [WIDTH-1:0] TOP = WIDTH'(LIMIT);

    logic [WIDTH-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clr)
            cnt_d = '0;
        else if (inc && (cnt_q != TOP))
            cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign cnt = cnt_q;
endmodule

// File: rtl/lrc_edge_detect.sv
module lrc_edge_detect (
    input  logic prev,
    input  logic cur,
    output logic rise
);
    assign rise = cur & ~prev;
endmodule

// File: rtl/link_reset_ctrl.sv
module link_reset_ctrl
    import lrc_pkg::*;
#(
    parameter int COLD_MIN       = 8,
    parameter int WARM_MIN       = 6,
    parameter int CONSUMER_EDGES = 5,
    parameter int ADDR_W         = 7
) (
    input  logic              clk,
    input  logic              por_n,
    input  logic              link_rst_n,
    input  logic              sync_in,
    input  logic              bclk_in,
    input  logic              xtal_sel,
    input  logic              wr_stb,
    input  logic [ADDR_W-1:0] wr_addr,
    output logic              hw_rst_o,
    output logic              reg_rst_o,
    output logic              link_active_o,
    output logic              bclk_consumer_o,
    output logic [1:0]        clk_src_o
);
    localparam int LOW_W  = $clog2(COLD_MIN);
    localparam int WARM_W = $clog2(WARM_MIN);
    localparam int EDGE_W = $clog2(CONSUMER_EDGES + 1);
    localparam logic [LOW_W-1:0]  LOW_HIT  = LOW_W'(COLD_MIN - 1);
    localparam logic [WARM_W-1:0] WARM_HIT = WARM_W'(WARM_MIN - 1);
    localparam logic [EDGE_W-1:0] EDGE_MIN = EDGE_W'(CONSUMER_EDGES);

    lrc_regs_t r_d, r_q;

    logic              bclk_rise;
    logic [LOW_W-1:0]  low_cnt;
    logic [WARM_W-1:0] warm_cnt;
    logic [EDGE_W-1:0] edge_cnt;
    logic              cold_hit, warm_hit, warm_clr;

    lrc_edge_detect u_bclk_edge (
        .prev (r_q.bclk_prev),
        .cur  (bclk_in),
        .rise (bclk_rise)
    );

    // length of the current low phase of the reset pin
    lrc_sat_counter #(.WIDTH(LOW_W), .LIMIT(COLD_MIN - 1)) u_low_cnt (
        .clk   (clk),
        .rst_n (por_n),
        .clr   (link_rst_n),
        .inc   (1'b1),
        .cnt   (low_cnt)
    );

    // bit-clock rising edges seen while the reset pin is low
    lrc_sat_counter #(.WIDTH(EDGE_W), .LIMIT(CONSUMER_EDGES)) u_edge_cnt (
        .clk   (clk),
        .rst_n (por_n),
        .clr   (link_rst_n),
        .inc   (bclk_rise),
        .cnt   (edge_cnt)
    );

    // SYNC-high run length with a quiet bit clock, only on a live link
    assign warm_clr = !sync_in || bclk_rise || !link_rst_n || (r_q.state != ST_ACTIVE);

    lrc_sat_counter #(.WIDTH(WARM_W), .LIMIT(WARM_MIN - 1)) u_warm_cnt (
        .clk   (clk),
        .rst_n (por_n),
        .clr   (warm_clr),
        .inc   (1'b1),
        .cnt   (warm_cnt)
    );

    assign cold_hit = !link_rst_n && (low_cnt == LOW_HIT);
    assign warm_hit = sync_in && !bclk_rise && link_rst_n && (warm_cnt == WARM_HIT);

    always_comb begin
        r_d           = r_q;
        r_d.bclk_prev = bclk_in;
        r_d.reg_pulse = 1'b0;

        if (!r_q.strap_done) begin
            r_d.strap      = xtal_sel;
            r_d.strap_done = 1'b1;
        end

        unique case (r_q.state)
            ST_COLD: begin
                if (link_rst_n) begin
                    r_d.state    = ST_ACTIVE;
                    r_d.consumer = (edge_cnt >= EDGE_MIN);
                end
            end
            ST_ACTIVE: begin
                if (cold_hit)
                    r_d.state = ST_COLD;
                else if (warm_hit)
                    r_d.state = ST_WARM;
                else if (wr_stb && (wr_addr == '0))
                    r_d.reg_pulse = 1'b1;
            end
            ST_WARM: begin
                if (cold_hit)
                    r_d.state = ST_COLD;
                else if (!sync_in)
                    r_d.state = ST_ACTIVE;
            end
            default: r_d.state = ST_COLD;
        endcase
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            r_q.state      <= ST_COLD;
            r_q.consumer   <= 1'b0;
            r_q.strap      <= 1'b1;
            r_q.strap_done <= 1'b0;
            r_q.reg_pulse  <= 1'b0;
            r_q.bclk_prev  <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    assign hw_rst_o        = (r_q.state == ST_COLD);
    assign reg_rst_o       = hw_rst_o | r_q.reg_pulse;
    assign link_active_o   = (r_q.state == ST_ACTIVE);
    assign bclk_consumer_o = r_q.consumer;
    assign clk_src_o       = r_q.consumer ? SRC_EXT_BCLK :
                             (r_q.strap ? SRC_XTAL_14M : SRC_XTAL_24M);
endmodule

// File: rtl/link_reset_ctrl_sva.sv
module link_reset_ctrl_sva #(
    parameter int ADDR_W = 7
) (
    input logic              clk,
    input logic              por_n,
    input logic              link_rst_n,
    input logic              sync_in,
    input logic              xtal_sel,
    input logic              wr_stb,
    input logic [ADDR_W-1:0] wr_addr,
    input logic              hw_rst_o,
    input logic              reg_rst_o,
    input logic              link_active_o,
    input logic              bclk_consumer_o,
    input logic [1:0]        clk_src_o
);
    // R2: a cold reset only ever follows a low reset pin
    a_r2_cold_from_pin: assert property (@(posedge clk) disable iff (!por_n)
        $rose(hw_rst_o) |-> $past(!link_rst_n));

    // R3: leaving cold reset needs a released pin and activates the link
    a_r3_release_activates: assert property (@(posedge clk) disable iff (!por_n)
        $fell(hw_rst_o) |-> (link_active_o && $past(link_rst_n)));

    // R4, R5: clock mode and source hold while no cold reset runs
    a_r5_src_stable: assert property (@(posedge clk) disable iff (!por_n)
        (!hw_rst_o && $past(!hw_rst_o)) |-> ($stable(clk_src_o) && $stable(bclk_consumer_o)));

    // R6: a register reset outside cold reset comes from a write to index zero
    a_r6_reg_pulse_cause: assert property (@(posedge clk) disable iff (!por_n)
        (reg_rst_o && !hw_rst_o) |-> $past(wr_stb && (wr_addr == '0)));

    // R7: the link drops without cold reset only after SYNC was high
    a_r7_warm_cause: assert property (@(posedge clk) disable iff (!por_n)
        ($fell(link_active_o) && !hw_rst_o) |-> $past(sync_in));

    // R7: no register reset while the link is down in a warm reset
    a_r7_warm_keeps_regs: assert property (@(posedge clk) disable iff (!por_n)
        (!link_active_o && !hw_rst_o) |-> !reg_rst_o);
endmodule

bind link_reset_ctrl link_reset_ctrl_sva #(.ADDR_W(ADDR_W)) u_sva (
    .clk             (clk),
    .por_n           (por_n),
    .link_rst_n      (link_rst_n),
    .sync_in         (sync_in),
    .xtal_sel        (xtal_sel),
    .wr_stb          (wr_stb),
    .wr_addr         (wr_addr),
    .hw_rst_o        (hw_rst_o),
    .reg_rst_o       (reg_rst_o),
    .link_active_o   (link_active_o),
    .bclk_consumer_o (bclk_consumer_o),
    .clk_src_o       (clk_src_o)
);

// File: tb/link_reset_ctrl_tb.sv
module link_reset_ctrl_tb;
    localparam int COLD_MIN = 8;
    localparam int WARM_MIN = 6;
    localparam int EDGES    = 5;
    localparam int ADDR_W   = 7;
    localparam int NVEC     = 5;

    // each entry: {edges to send, expected consumer, expected source code}
    localparam logic [7:0] VEC_EDGES [NVEC] = '{8'd0, 8'd4, 8'd5, 8'd3, 8'd7};
    localparam logic       VEC_CONS  [NVEC] = '{1'b0, 1'b0, 1'b1, 1'b0, 1'b1};
    localparam logic [1:0] VEC_SRC   [NVEC] = '{2'b00, 2'b00, 2'b10, 2'b00, 2'b10};

    logic clk = 1'b0;
    logic por_n = 1'b0;
    logic link_rst_n = 1'b0;
    logic sync_in = 1'b0;
    logic bclk_in = 1'b0;
    logic xtal_sel = 1'b0;
    logic wr_stb = 1'b0;
    logic [ADDR_W-1:0] wr_addr = '0;
    logic hw_rst_o, reg_rst_o, link_active_o, bclk_consumer_o;
    logic [1:0] clk_src_o;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    link_reset_ctrl #(
        .COLD_MIN(COLD_MIN), .WARM_MIN(WARM_MIN),
        .CONSUMER_EDGES(EDGES), .ADDR_W(ADDR_W)
    ) u_dut (
        .clk(clk), .por_n(por_n), .link_rst_n(link_rst_n), .sync_in(sync_in),
        .bclk_in(bclk_in), .xtal_sel(xtal_sel), .wr_stb(wr_stb), .wr_addr(wr_addr),
        .hw_rst_o(hw_rst_o), .reg_rst_o(reg_rst_o), .link_active_o(link_active_o),
        .bclk_consumer_o(bclk_consumer_o), .clk_src_o(clk_src_o)
    );

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic send_edges(input int n);
        for (int i = 0; i < n; i++) begin
            bclk_in = 1'b1; tick(2);
            bclk_in = 1'b0; tick(2);
        end
    endtask

    task automatic cold_cycle(input int n_edges);
        link_rst_n = 1'b0;
        send_edges(n_edges);
        tick(COLD_MIN + 2);
        check("R2 hw_rst held", int'(hw_rst_o), 1);
        link_rst_n = 1'b1;
        tick(1);
    endtask

    initial begin
        tick(3);
        check("R1 hw_rst", int'(hw_rst_o), 1);
        check("R1 reg_rst", int'(reg_rst_o), 1);
        check("R1 link", int'(link_active_o), 0);
        check("R1 consumer", int'(bclk_consumer_o), 0);
        check("R1 src", int'(clk_src_o), 1);
        por_n = 1'b1;
        tick(2);
        xtal_sel = 1'b1;
        link_rst_n = 1'b1;
        tick(1);
        check("R3 link up", int'(link_active_o), 1);
        check("R5 strap 0 latched", int'(clk_src_o), 0);

        // R4 consumer decision table
        for (int v = 0; v < NVEC; v++) begin
            cold_cycle(int'(VEC_EDGES[v]));
            check("R3 link after cold", int'(link_active_o), 1);
            check("R3 hw_rst cleared", int'(hw_rst_o), 0);
            check("R4 consumer", int'(bclk_consumer_o), int'(VEC_CONS[v]));
            check("R4 src", int'(clk_src_o), int'(VEC_SRC[v]));
        end

        // R2 cold threshold
        tick(2);
        link_rst_n = 1'b0;
        tick(COLD_MIN - 1);
        check("R2 short low ignored", int'(hw_rst_o), 0);
        link_rst_n = 1'b1;
        tick(2);
        check("R2 link kept", int'(link_active_o), 1);
        link_rst_n = 1'b0;
        tick(COLD_MIN - 1);
        check("R2 below count", int'(hw_rst_o), 0);
        tick(1);
        check("R2 cold at count", int'(hw_rst_o), 1);
        check("R2 reg_rst in cold", int'(reg_rst_o), 1);
        check("R2 link down", int'(link_active_o), 0);
        link_rst_n = 1'b1;
        tick(1);
        check("R4 refreshed producer", int'(bclk_consumer_o), 0);

        // R6 register reset
        tick(2);
        wr_addr = 7'd0; wr_stb = 1'b1;
        tick(1);
        wr_stb = 1'b0;
        check("R6 reg_rst pulse", int'(reg_rst_o), 1);
        check("R6 hw_rst quiet", int'(hw_rst_o), 0);
        check("R6 link kept", int'(link_active_o), 1);
        tick(1);
        check("R6 pulse one cycle", int'(reg_rst_o), 0);
        wr_addr = 7'd5; wr_stb = 1'b1;
        tick(1);
        wr_stb = 1'b0;
        check("R6 other address", int'(reg_rst_o), 0);

        // R7 warm reset with quiet bit clock
        cold_cycle(6);
        tick(2);
        sync_in = 1'b1;
        tick(WARM_MIN - 1);
        check("R7 below count", int'(link_active_o), 1);
        tick(1);
        check("R7 link down", int'(link_active_o), 0);
        check("R7 no reg_rst", int'(reg_rst_o), 0);
        check("R7 no hw_rst", int'(hw_rst_o), 0);
        check("R7 consumer kept", int'(bclk_consumer_o), 1);
        tick(3);
        sync_in = 1'b0;
        tick(1);
        check("R7 link back", int'(link_active_o), 1);
        check("R7 src kept", int'(clk_src_o), 2);

        // R8 toggling bit clock blocks warm reset
        tick(2);
        sync_in = 1'b1;
        send_edges(4);
        check("R8 no warm with clock", int'(link_active_o), 1);
        sync_in = 1'b0;
        tick(2);

        // R9 SYNC high during cold reset
        link_rst_n = 1'b0;
        sync_in = 1'b1;
        tick(COLD_MIN + WARM_MIN);
        link_rst_n = 1'b1;
        tick(1);
        check("R9 link up with sync high", int'(link_active_o), 1);
        tick(WARM_MIN - 2);
        check("R9 count restarted", int'(link_active_o), 1);
        sync_in = 1'b0;
        tick(2);

        // R5 strap not re-latched by cold reset, then new power-on
        check("R5 strap ignored", int'(clk_src_o), 0);
        por_n = 1'b0;
        link_rst_n = 1'b0;
        tick(2);
        por_n = 1'b1;
        tick(2);
        link_rst_n = 1'b1;
        tick(1);
        xtal_sel = 1'b0;
        tick(2);
        check("R5 strap 1 latched", int'(clk_src_o), 1);
        cold_cycle(0);
        check("R5 strap kept", int'(clk_src_o), 1);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule